// File: doc/BRIEF.md
# Banked Host Register Window

This block is the host-facing register front end of a network controller. A 16-bit host bus reaches it through a narrow window of eight word offsets. The registers behind that window are spread over four banks. A bank-select register sits at the top offset of the window in every bank, so the host can always move to another bank. The host reads the current bank number from it, and a fixed identification byte in its upper half lets software recognise the part.

Bank 2 holds the interrupt group. It has a sticky status register, a write-one-to-clear acknowledge at the same offset, and an enable mask. Single-cycle event pulses from the datapath set the status bits. One registered interrupt line is raised while any enabled bit is pending. Bank 3 holds a read-only revision word with a chip code and a revision code in separate nibbles. Reads have no side effects and return data in the cycle the address is presented. Writes take effect at the next clock edge.

Top module: `bankwin_top`

## Requirements
- R1: After a synchronous active-low reset the bank is 0, the mask is 0, every status bit is 0 and `irq` is 0.
- R2: A write to the bank-select register keeps only the low two data bits as the bank. A read of it returns the bank in bits [1:0] and zeros in bits [7:2].
- R3: Bits [15:8] of the bank-select register always read the identification byte 0x33, including right after a write of 0x0000 or 0xFFFF.
- R4: The bank-select register is at word offset 7 in each of the four banks.
- R5: Word offset 0 of bank 3 reads chip code 0x9 in bits [7:4], revision 0x1 in bits [3:0] and zeros above. Writes there change nothing.
- R6: A 1 on `evt_in[i]` sets status bit i. The bits are receive done (0), transmit error (1), transmit empty (2), allocation done (3), receive overrun (4) and PHY event (5). Status reads at bank 2 offset 0 in bits [5:0] and stays set until it is acknowledged.
- R7: A write to bank 2 offset 0 clears each status bit whose data bit is 1 and leaves the other bits unchanged.
- R8: When an event and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R9: The mask is read and written at bank 2 offset 1, bits [5:0]. `irq` is a register that follows (status AND mask) != 0 one clock later.
- R10: With the mask at 0, `irq` stays 0 whatever is pending.
- R11: Offsets 0 and 1 in banks 0 and 1 read 0. Writes there do not touch the status or the mask.
- R12: Offsets in the window that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Word offset within the window |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for `host_addr` in the current bank, combinational |
| evt_in | input | 6 | Event pulses from the datapath, one per status bit |
| irq | output | 1 | Registered interrupt request |

## Verification
Read data depends only on the current address and register state, so it is due in the same cycle and is sampled a moment after the address changes. A write or an event that is held during one cycle shows in `host_rdata` after the edge that ends that cycle. `irq` takes one more edge, and the bench checks that it is still low right after a new event before it checks it one cycle later. Checks that need a bank change do the bank write first and then read, so every sample falls after the last register on its path.

// File: rtl/bankwin_pkg.sv
// Package: shared register-select type for the banked window.
// Assumes every decoded location maps to exactly one of these targets.
package bankwin_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BANK,
        SEL_STAT,
        SEL_MASK,
        SEL_REV
    } reg_sel_e;

endpackage

// File: rtl/bankwin_decode.sv
// Module: bankwin_decode
// Maps the current bank and word offset onto one register target.
// Assumes the bank-select offset is the topmost word of the window and
// overrides every bank; the other targets exist only in their own bank.
module bankwin_decode
    import bankwin_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int BANK_W    = 2,
    parameter int IRQ_BANK  = 2,
    parameter int INFO_BANK = 3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] OFF_BANKSEL = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] OFF_STAT    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_MASK    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_REV     = ADDR_W'(0);
    localparam logic [BANK_W-1:0] B_IRQ       = BANK_W'(IRQ_BANK);
    localparam logic [BANK_W-1:0] B_INFO      = BANK_W'(INFO_BANK);

    // Pick the target; the bank-select offset wins in every bank.
    always_comb begin
        sel = SEL_NONE;
        if (addr == OFF_BANKSEL)
            sel = SEL_BANK;
        else if (bank == B_IRQ && addr == OFF_STAT)
            sel = SEL_STAT;
        else if (bank == B_IRQ && addr == OFF_MASK)
            sel = SEL_MASK;
        else if (bank == B_INFO && addr == OFF_REV)
            sel = SEL_REV;
    end
endmodule

// File: rtl/bankwin_bank_reg.sv
// Module: bankwin_bank_reg
// Holds the selected bank number.
// Assumes the caller passes only the writable low data bits.
module bankwin_bank_reg #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BANK_W-1:0] wbank,
    output logic [BANK_W-1:0] bank
);
    // Load a new bank on write, return to bank 0 on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (we)
            bank <= wbank;
    end
endmodule

// File: rtl/bankwin_irq.sv
// Module: bankwin_irq
// Sticky event status, write-one-to-clear acknowledge, enable mask and
// a registered interrupt request.
// Assumes events are level-sampled each cycle; a set beats a same-cycle clear.
module bankwin_irq #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            ack_we,
    input  logic            mask_we,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] mask,
    output logic            irq
);
    logic [NSRC-1:0] clr_bits;

    // Bits the host asks to clear this cycle.
    always_comb clr_bits = ack_we ? wbits : '0;

    // Update pending bits: clear acknowledged ones, then add new events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (status & ~clr_bits) | evt;
    end

    // Hold the enable mask written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_we)
            mask <= wbits;
    end

    // Register the request so the output never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(status & mask);
    end
endmodule

// File: rtl/bankwin_top.sv
// Module: bankwin_top
// Banked host register window: bank select with identification byte,
// interrupt group in one bank, constant revision word in the last bank.
// Assumes single-cycle write strobes and side-effect-free reads.
module bankwin_top
    import bankwin_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 3,
    parameter int          BANK_W    = 2,
    parameter int          NSRC      = 6,
    parameter int          FIELD_W   = 4,
    parameter logic [7:0]  ID_CODE   = 8'h33,
    parameter logic [3:0]  CHIP_CODE = 4'h9,
    parameter logic [3:0]  REV_CODE  = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [NSRC-1:0]   evt_in,
    output logic              irq
);
    localparam int NBANKS    = 1 << BANK_W;
    localparam int ID_W      = DATA_W / 2;
    localparam int IRQ_BANK  = 2;
    localparam int INFO_BANK = NBANKS - 1;

    reg_sel_e          sel;
    logic [BANK_W-1:0] bank;
    logic [NSRC-1:0]   status;
    logic [NSRC-1:0]   mask;
    logic              bank_we;
    logic              ack_we;
    logic              mask_we;

    bankwin_decode #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .IRQ_BANK(IRQ_BANK), .INFO_BANK(INFO_BANK)
    ) u_decode (
        .bank(bank), .addr(host_addr), .sel(sel)
    );

    // Turn the decoded target into per-register write enables.
    always_comb begin
        bank_we = host_wr && (sel == SEL_BANK);
        ack_we  = host_wr && (sel == SEL_STAT);
        mask_we = host_wr && (sel == SEL_MASK);
    end

    bankwin_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(bank_we),
        .wbank(host_wdata[BANK_W-1:0]), .bank(bank)
    );

    bankwin_irq #(.NSRC(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt_in),
        .ack_we(ack_we), .mask_we(mask_we),
        .wbits(host_wdata[NSRC-1:0]),
        .status(status), .mask(mask), .irq(irq)
    );

    // Build the read word for the decoded target; unmapped reads are 0.
    always_comb begin
        host_rdata = '0;
        unique case (sel)
            SEL_BANK: begin
                host_rdata[DATA_W-1 -: ID_W] = ID_CODE[ID_W-1:0];
                host_rdata[BANK_W-1:0]       = bank;
            end
            SEL_STAT: host_rdata[NSRC-1:0] = status;
            SEL_MASK: host_rdata[NSRC-1:0] = mask;
            SEL_REV: begin
                host_rdata[2*FIELD_W-1:FIELD_W] = CHIP_CODE[FIELD_W-1:0];
                host_rdata[FIELD_W-1:0]         = REV_CODE[FIELD_W-1:0];
            end
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bankwin_chk.sv
// Module: bankwin_chk
// Temporal checks on the register window, bound into bankwin_top.
// Assumes the default geometry: bank-select at the topmost offset.
module bankwin_chk #(
    parameter int          DATA_W  = 16,
    parameter int          ADDR_W  = 3,
    parameter int          BANK_W  = 2,
    parameter int          NSRC    = 6,
    parameter logic [7:0]  ID_CODE = 8'h33
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_rdata,
    input logic [NSRC-1:0]   evt_in,
    input logic              irq,
    input logic [BANK_W-1:0] bank,
    input logic [NSRC-1:0]   status,
    input logic [NSRC-1:0]   mask,
    input logic              ack_we
);
    localparam logic [ADDR_W-1:0] OFF_BANKSEL = {ADDR_W{1'b1}};

    // R1: reset leaves the request low.
    p_irq_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !irq);

    // R2: the bank only changes on a write to the bank-select offset.
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == OFF_BANKSEL) |=> $stable(bank));

    // R3: identification byte on every bank-select read.
    p_id_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == OFF_BANKSEL) |-> (host_rdata[DATA_W-1 -: 8] == ID_CODE));

    // R6: pending bits stay set without an acknowledge.
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_we |=> ((status & $past(status)) == $past(status)));

    // R8: every event lands in status, even against an acknowledge.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((status & $past(evt_in)) == $past(evt_in)));

    // R10: a cleared mask keeps the request low on the next cycle.
    p_mask_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq);
endmodule

bind bankwin_top bankwin_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
    .NSRC(NSRC), .ID_CODE(ID_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rdata(host_rdata), .evt_in(evt_in), .irq(irq), .bank(bank),
    .status(status), .mask(mask), .ack_we(ack_we)
);

// File: tb/bankwin_top_tb.sv
// Bench for bankwin_top: a table of read vectors across banks, then
// directed tests for the interrupt group, latency and reset.
module bankwin_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [5:0]  evt_in = '0;
    logic        irq;
    int          total = 0;
    int          bad = 0;

    bankwin_top u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    always #10 clk = ~clk;

    // {bank, offset, expected read}
    localparam int NV = 12;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 3'd7, 16'h3300},  // R4 R3
        {2'd1, 3'd7, 16'h3301},  // R4 R2
        {2'd2, 3'd7, 16'h3302},  // R4
        {2'd3, 3'd7, 16'h3303},  // R4
        {2'd3, 3'd0, 16'h0091},  // R5
        {2'd0, 3'd0, 16'h0000},  // R11
        {2'd0, 3'd1, 16'h0000},  // R11
        {2'd1, 3'd0, 16'h0000},  // R11
        {2'd3, 3'd1, 16'h0000},  // R12
        {2'd2, 3'd3, 16'h0000},  // R12
        {2'd2, 3'd0, 16'h0000},  // R1 status
        {2'd2, 3'd1, 16'h0000}   // R1 mask
    };
    localparam string VTAG [NV] = '{"R4","R2","R4","R4","R5","R11",
                                    "R11","R11","R12","R12","R1","R1"};

    task automatic check(input string tag, input logic [15:0] got,
                         input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {15'd0, irq}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            wr(3'd7, {14'd0, VEC[i][20:19]});
            rd(VEC[i][18:16], v);
            check(VTAG[i], v, VEC[i][15:0]);
        end

        // R2 R3: only low bits kept, ID byte survives all-ones and zero.
        wr(3'd7, 16'hFFFF); rd(3'd7, v); check("R2 R3 ones", v, 16'h3303);
        wr(3'd0, 16'hFFFF); rd(3'd0, v); check("R5 write ignored", v, 16'h0091);
        wr(3'd7, 16'h0000); rd(3'd7, v); check("R3 zero", v, 16'h3300);

        // R11: mask/ack offsets in bank 0 do not reach the interrupt group.
        wr(3'd1, 16'h003F);
        wr(3'd7, 16'h0002);
        rd(3'd1, v); check("R11 mask untouched", v, 16'h0000);

        // R9: mask read-back.
        wr(3'd1, 16'h003F);
        rd(3'd1, v); check("R9 mask", v, 16'h003F);

        // R6 R9: event sets status; irq lags status by one edge.
        pulse(6'h05);
        rd(3'd0, v); check("R6 status", v, 16'h0005);
        check("R9 irq latency", {15'd0, irq}, 16'd0);
        @(negedge clk);
        check("R9 irq up", {15'd0, irq}, 16'd1);
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R6 sticky", v, 16'h0005);

        // R7: acknowledge clears only the written ones.
        wr(3'd0, 16'h0001);
        rd(3'd0, v); check("R7 ack", v, 16'h0004);

        // R8: event and acknowledge on bit 1 together; bit 2 just clears.
        @(negedge clk);
        host_addr = 3'd0; host_wdata = 16'h0006; host_wr = 1'b1; evt_in = 6'h02;
        @(negedge clk);
        host_wr = 1'b0; evt_in = '0;
        rd(3'd0, v); check("R8 set wins", v, 16'h0002);

        // R10: mask cleared blocks the request while bit 1 pends.
        wr(3'd1, 16'h0000);
        @(negedge clk);
        check("R10 irq blocked", {15'd0, irq}, 16'd0);
        pulse(6'h3F);
        @(negedge clk);
        check("R10 irq still blocked", {15'd0, irq}, 16'd0);

        // R11: acknowledge in bank 0 leaves status alone.
        wr(3'd7, 16'h0000);
        wr(3'd0, 16'h003F);
        wr(3'd7, 16'h0002);
        rd(3'd0, v); check("R11 ack elsewhere", v, 16'h003F);

        // R1: reset mid-run.
        wr(3'd1, 16'h003F);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", {15'd0, irq}, 16'd0);
        rd(3'd7, v); check("R1 bank after reset", v, 16'h3300);
        wr(3'd7, 16'h0002);
        rd(3'd0, v); check("R1 status after reset", v, 16'h0000);
        rd(3'd1, v); check("R1 mask after reset", v, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule